// File: doc/BRIEF.md
# NCO Phase and Frequency Controller

This block produces the phase argument for a quadrature numerically controlled oscillator. A 32-bit phase accumulator steps each enabled clock by a frequency word. That word is the sum of a center-frequency register and a frequency-offset register. A 16-bit phase word is added to the upper half of the accumulator to form the sine/cosine argument. The lower 16 accumulator bits are also brought out. A sine/cosine lookup downstream turns these into a rotating vector.

A processor loads three control registers through a 16-bit write port: center frequency, frequency offset and phase control. Separate active-low strobes, each registered on the clock, copy these control registers into the working registers and enable the accumulator. Other strobes can:

- zero the offset path without clearing the offset register;
- zero the accumulator feedback without clearing the accumulator;
- inject a carry of one into the sum.

The phase word comes either from the phase control register or from two quadrant-modulation pins, which give steps of a quarter turn.

Top module: `nco_phase_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) clears every register and registered control, so `phase_arg` and `acc_low` read 0 after reset.
- R2: A write captures `wr_data` on the clock edge at which `wr_n` is first seen high after being low, provided `cs_n` is low at that edge. Address 0 writes a 16-bit staging register. Address 1 sets the center control word to {wr_data, staging}. Address 2 sets the offset control word to {wr_data, staging}. Address 3 sets the phase control word to wr_data. A strobe with `cs_n` high changes nothing.
- R3: The strobes `ld_ctr_n`, `ld_ofs_n`, `ld_ph_n` and `acc_en_n` are active low and registered. A low sampled at edge k acts at edge k+1. Holding `acc_en_n` low for N cycles gives exactly N accumulator steps. Working registers do not follow the control words unless their strobe is asserted.
- R4: Each enabled step sets acc = acc + center + offset, modulo 2^32, with no overflow flag. Without enable, acc holds.
- R5: While the registered `ofs_zero_n` is low, the offset contributes zero to the sum. The offset register keeps its value and is used again once the control is released.
- R6: While the registered `fb_zero_n` is low, an enabled step sets acc = center + offset, dropping the old accumulator value.
- R7: While the registered `cin_n` is low, an enabled step adds one more to the sum.
- R8: On a phase load, a registered `ph_src_sel` high selects the phase control word. A low selects {quad_mod, 14'b0}, a quarter-turn offset of 0 to 3 quadrants.
- R9: `phase_arg` = acc[31:16] + phase register (mod 2^16), and `acc_low` = acc[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Write port select, active low |
| wr_n | input | 1 | Write strobe; rising edge writes |
| wr_addr | input | 2 | Write destination |
| wr_data | input | 16 | Write data |
| ld_ctr_n | input | 1 | Load center register, active low |
| ld_ofs_n | input | 1 | Load offset register, active low |
| ld_ph_n | input | 1 | Load phase register, active low |
| acc_en_n | input | 1 | Accumulator step enable, active low |
| ofs_zero_n | input | 1 | Zero offset path, active low |
| fb_zero_n | input | 1 | Zero accumulator feedback, active low |
| cin_n | input | 1 | Carry in, active low |
| ph_src_sel | input | 1 | Phase source: 1 control word, 0 quadrant pins |
| quad_mod | input | 2 | Quadrant modulation bits |
| phase_arg | output | 16 | Sine/cosine argument |
| acc_low | output | 16 | Low 16 bits of the accumulator |

## Verification
On every cycle, the assertions check the accumulator step arithmetic for plain, offset-zeroed, feedback-zeroed and carry steps. They also check that the accumulator holds when not enabled, that the offset register survives a clear, and the layout of a quadrant-sourced phase word. The bench scenarios are what show the write port's address map and staging, the rejection of a deselected write, and the one-cycle strobe latency seen at the ports. They also show multi-step accumulation with wraparound across a sweep of frequency words and step counts.

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic [1:0]              wr_addr,
  input  logic [PH_W-1:0]         wr_data,
  input  logic                    ld_ctr_n,
  input  logic                    ld_ofs_n,
  input  logic                    ld_ph_n,
  input  logic                    acc_en_n,
  input  logic                    ofs_zero_n,
  input  logic                    fb_zero_n,
  input  logic                    cin_n,
  input  logic                    ph_src_sel,
  input  logic [1:0]              quad_mod,
  output logic [PH_W-1:0]         phase_arg,
  output logic [ACC_W-PH_W-1:0]   acc_low
);
  localparam int LO_W = ACC_W - PH_W;

  logic            wr_n_q;
  logic [LO_W-1:0] stage;
  logic [ACC_W-1:0] ctr_ctl, ofs_ctl;
  logic [PH_W-1:0]  ph_ctl;

  logic ld_ctr_q, ld_ofs_q, ld_ph_q, acc_en_q, ofs_zero_q, fb_zero_q, cin_q, src_q;
  logic [1:0] quad_q;

  logic [ACC_W-1:0] ctr, ofs, acc;
  logic [PH_W-1:0]  phreg;

  logic             wr_fire;
  logic [ACC_W-1:0] freq_sum, acc_next;
  logic [PH_W-1:0]  ph_src;

  assign wr_fire  = !cs_n && wr_n && !wr_n_q;
  assign freq_sum = ctr + (ofs_zero_q ? '0 : ofs);
  assign acc_next = (fb_zero_q ? '0 : acc) + freq_sum + ACC_W'(cin_q);
  assign ph_src   = src_q ? ph_ctl : {quad_q, {(PH_W-2){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q  <= 1'b1;
      stage   <= '0;
      ctr_ctl <= '0;
      ofs_ctl <= '0;
      ph_ctl  <= '0;
    end else begin
      wr_n_q <= wr_n;
      if (wr_fire) begin
        case (wr_addr)
          2'd0: stage   <= wr_data[LO_W-1:0];
          2'd1: ctr_ctl <= {wr_data, stage};
          2'd2: ofs_ctl <= {wr_data, stage};
          default: ph_ctl <= wr_data;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_ctr_q   <= 1'b0;
      ld_ofs_q   <= 1'b0;
      ld_ph_q    <= 1'b0;
      acc_en_q   <= 1'b0;
      ofs_zero_q <= 1'b0;
      fb_zero_q  <= 1'b0;
      cin_q      <= 1'b0;
      src_q      <= 1'b0;
      quad_q     <= '0;
    end else begin
      ld_ctr_q   <= !ld_ctr_n;
      ld_ofs_q   <= !ld_ofs_n;
      ld_ph_q    <= !ld_ph_n;
      acc_en_q   <= !acc_en_n;
      ofs_zero_q <= !ofs_zero_n;
      fb_zero_q  <= !fb_zero_n;
      cin_q      <= !cin_n;
      src_q      <= ph_src_sel;
      quad_q     <= quad_mod;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr   <= '0;
      ofs   <= '0;
      phreg <= '0;
      acc   <= '0;
    end else begin
      if (ld_ctr_q) ctr   <= ctr_ctl;
      if (ld_ofs_q) ofs   <= ofs_ctl;
      if (ld_ph_q)  phreg <= ph_src;
      if (acc_en_q) acc   <= acc_next;
    end
  end

  assign phase_arg = acc[ACC_W-1:LO_W] + phreg;
  assign acc_low   = acc[LO_W-1:0];
endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] ctr,
  input logic [ACC_W-1:0] ofs,
  input logic [PH_W-1:0]  phreg,
  input logic             acc_en_q,
  input logic             ofs_zero_q,
  input logic             fb_zero_q,
  input logic             cin_q,
  input logic             ld_ofs_q,
  input logic             ld_ph_q,
  input logic             src_q,
  input logic [1:0]       quad_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc == '0 && phreg == '0 && ctr == '0 && ofs == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_en_q |=> $stable(acc));

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (acc_en_q && !ofs_zero_q && !fb_zero_q && !cin_q)
    |=> acc == ACC_W'($past(acc) + $past(ctr) + $past(ofs)));

  a_r5_ofs_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_en_q && ofs_zero_q && !fb_zero_q && !cin_q)
    |=> acc == ACC_W'($past(acc) + $past(ctr)));

  a_r5_ofs_kept: assert property (@(posedge clk) disable iff (rst)
    (ofs_zero_q && !ld_ofs_q) |=> $stable(ofs));

  a_r6_fb_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_en_q && fb_zero_q && !ofs_zero_q && !cin_q)
    |=> acc == ACC_W'($past(ctr) + $past(ofs)));

  a_r7_carry: assert property (@(posedge clk) disable iff (rst)
    (acc_en_q && cin_q && !ofs_zero_q && !fb_zero_q)
    |=> acc == ACC_W'($past(acc) + $past(ctr) + $past(ofs) + 1));

  a_r8_quad_src: assert property (@(posedge clk) disable iff (rst)
    (ld_ph_q && !src_q)
    |=> (phreg[PH_W-3:0] == '0 && phreg[PH_W-1:PH_W-2] == $past(quad_q)));
endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .acc(acc), .ctr(ctr), .ofs(ofs), .phreg(phreg),
  .acc_en_q(acc_en_q), .ofs_zero_q(ofs_zero_q), .fb_zero_q(fb_zero_q),
  .cin_q(cin_q), .ld_ofs_q(ld_ofs_q), .ld_ph_q(ld_ph_q), .src_q(src_q),
  .quad_q(quad_q)
);

// File: tb/tb_nco_phase_ctrl.sv
`timescale 1ns/1ps
module tb_nco_phase_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ld_ctr_n = 1'b1, ld_ofs_n = 1'b1, ld_ph_n = 1'b1, acc_en_n = 1'b1;
  logic ofs_zero_n = 1'b1, fb_zero_n = 1'b1, cin_n = 1'b1, ph_src_sel = 1'b1;
  logic [1:0] quad_mod = '0;
  logic [15:0] phase_arg, acc_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nco_phase_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_ctr_n(ld_ctr_n), .ld_ofs_n(ld_ofs_n),
    .ld_ph_n(ld_ph_n), .acc_en_n(acc_en_n), .ofs_zero_n(ofs_zero_n),
    .fb_zero_n(fb_zero_n), .cin_n(cin_n), .ph_src_sel(ph_src_sel),
    .quad_mod(quad_mod), .phase_arg(phase_arg), .acc_low(acc_low)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] acc_now(input logic [15:0] ph);
    return {phase_arg - ph, acc_low};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic wr(input logic cs, input logic [1:0] a, input logic [15:0] d);
    cs_n = cs; wr_addr = a; wr_data = d; wr_n = 1'b0;
    step(1);
    wr_n = 1'b1;
    step(1);
    cs_n = 1'b1;
  endtask

  task automatic set_ctr(input logic [31:0] v);
    wr(1'b0, 2'd0, v[15:0]);
    wr(1'b0, 2'd1, v[31:16]);
    ld_ctr_n = 1'b0; step(1); ld_ctr_n = 1'b1; step(2);
  endtask

  task automatic set_ofs(input logic [31:0] v);
    wr(1'b0, 2'd0, v[15:0]);
    wr(1'b0, 2'd2, v[31:16]);
    ld_ofs_n = 1'b0; step(1); ld_ofs_n = 1'b1; step(2);
  endtask

  task automatic run(input int n);
    acc_en_n = 1'b0; step(n); acc_en_n = 1'b1; step(2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c, o, base, exp;
    step(1);
    do_reset();
    chk("R1 reset phase_arg", {16'h0, phase_arg}, 32'h0);
    chk("R1 reset acc_low", {16'h0, acc_low}, 32'h0);

    // R4 sweep with wraparound: acc = n*(c+o) mod 2^32
    for (int i = 0; i < 6; i++) begin
      c = 32'h0123_4567 * (i + 1) + 32'h9000_0000 * (i % 2);
      o = 32'hFEDC_0000 + 32'h0000_1111 * i;
      for (int n = 1; n <= 4; n++) begin
        do_reset();
        set_ctr(c);
        set_ofs(o);
        run(n);
        chk("R4 accumulate", acc_now(16'h0), 32'(n) * (c + o));
      end
    end

    // R1 mid-run reset
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    chk("R1 reset after run", acc_now(16'h0), 32'h0);

    // R2 deselected write ignored, then proper write
    do_reset();
    wr(1'b1, 2'd0, 16'h5678);
    wr(1'b1, 2'd1, 16'h1234);
    ld_ctr_n = 1'b0; step(1); ld_ctr_n = 1'b1; step(2);
    run(1);
    chk("R2 cs_n high write ignored", acc_now(16'h0), 32'h0);
    set_ctr(32'h1234_5678);
    run(1);
    chk("R2 center staged write", acc_now(16'h0), 32'h1234_5678);

    // R3 latency: one edge to register, next edge acts
    do_reset();
    set_ctr(32'h0000_0100);
    acc_en_n = 1'b0; step(1);
    chk("R3 no step at capture edge", acc_now(16'h0), 32'h0);
    acc_en_n = 1'b1; step(1);
    chk("R3 step one edge later", acc_now(16'h0), 32'h100);
    step(3);
    chk("R3 single step only", acc_now(16'h0), 32'h100);
    // R3 control word without its load strobe does not reach the working register
    wr(1'b0, 2'd0, 16'h0000);
    wr(1'b0, 2'd1, 16'h0100);
    run(1);
    chk("R3 center unchanged without load", acc_now(16'h0), 32'h200);

    // R7 carry
    do_reset();
    set_ctr(32'h0000_1000);
    set_ofs(32'h0000_0010);
    cin_n = 1'b0; acc_en_n = 1'b0; step(3);
    cin_n = 1'b1; acc_en_n = 1'b1; step(2);
    chk("R7 carry adds one per step", acc_now(16'h0), 32'd3 * 32'h1011);

    // R6 feedback zero
    fb_zero_n = 1'b0; acc_en_n = 1'b0; step(1);
    fb_zero_n = 1'b1; acc_en_n = 1'b1; step(2);
    chk("R6 feedback zeroed", acc_now(16'h0), 32'h1010);

    // R5 offset zero then restore
    do_reset();
    set_ctr(32'h0002_0000);
    set_ofs(32'h0000_0300);
    ofs_zero_n = 1'b0; acc_en_n = 1'b0; step(2);
    ofs_zero_n = 1'b1; acc_en_n = 1'b1; step(2);
    chk("R5 offset path zeroed", acc_now(16'h0), 32'h0004_0000);
    run(2);
    chk("R5 offset retained", acc_now(16'h0), 32'h0004_0000 + 32'd2 * 32'h0002_0300);

    // R8 / R9 phase source
    base = acc_now(16'h0);
    ph_src_sel = 1'b1;
    wr(1'b0, 2'd3, 16'hC0DE);
    ld_ph_n = 1'b0; step(1); ld_ph_n = 1'b1; step(2);
    chk("R8 R9 control-word phase", {16'h0, phase_arg}, {16'h0, base[31:16] + 16'hC0DE});
    chk("R9 acc_low", {16'h0, acc_low}, {16'h0, base[15:0]});
    ph_src_sel = 1'b0;
    for (int m = 0; m < 4; m++) begin
      quad_mod = 2'(m);
      ld_ph_n = 1'b0; step(1); ld_ph_n = 1'b1; step(2);
      exp = {16'h0, base[31:16] + {2'(m), 14'h0}};
      chk("R8 quadrant phase", {16'h0, phase_arg}, exp);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule